// File: doc/BRIEF.md
# Configurable Routing Multiplexer

This block chooses one of N single-bit data inputs for a programmable routing fabric. The choice comes from a static vector of configuration bits, which some other part of the chip loads. At elaboration, a parameter picks one of three ways to store the select:

- **Flat one-hot:** one bit per input.
- **Tree:** built from 2:1 stages, with one bit per stage.
- **Flat encoded:** a compact binary code that a small local decoder turns into the one-hot select.

An optional constant source can be appended as one more input. A fabric can then park an unused route at a known level instead of leaving it floating. The path from data and configuration to the output is purely combinational. The block has no clock and no reset.

The design is used by instantiating it with the input count, the select style, and the constant options. The configuration port width follows from those parameters.

Top module: `rmux_route`

## Requirements
- R1: In flat one-hot style (STYLE = SEL_ONEHOT) the configuration vector has one bit per source, and setting only bit k drives source k to the output.
- R2: In flat one-hot style, when several configuration bits are set the source with the lowest set bit index wins. When no bit is set, the output is 0.
- R3: In tree style (STYLE = SEL_TREE) there are T-1 configuration bits, one per 2:1 node, where T is the source count.
  - The nodes are numbered 0 (root) to T-2.
  - Node k has a left child 2k+1, taken when its bit is 0, and a right child 2k+2, taken when its bit is 1.
  - Indices T-1 to 2T-2 are the leaves for sources 0 to T-1.
- R4: In flat encoded style (STYLE = SEL_ENCODED) the configuration is an unsigned binary code of max(1, ceil(log2 T)) bits. Code k, for k < T, drives source k to the output (code 000 on an 8-input block selects source 0).
- R5: In flat encoded style, a code greater than or equal to T drives the output to 0.
- R6: With CONST_EN = 1 one extra source is appended at index N_IN, so T = N_IN + 1. Its level is CONST_VAL, which defaults to 0. With CONST_EN = 0, T = N_IN.
- R7: The output is a combinational function of data and configuration. It settles in the same time step as any input change, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | N_IN | Single-bit data sources, bit k is source k |
| cfg_in | input | cfg_bits(STYLE, T) | Static select configuration, format set by STYLE |
| mux_out | output | 1 | Selected source |

## Verification
The bench aims at the configurations that the one-hot and encoded formats leave undefined or easy to get wrong.

- **All-zero and multi-hot patterns.** A design that ORs the selected inputs would report 1 where the lowest-index rule demands the lower source. A design that defaults to source 0 would echo data where 0 is required.
- **Tree node numbering.** Every node pattern is swept for 4 and 8 inputs, so a mirrored child order or a mis-indexed leaf shows up as the wrong source on half the paths.
- **Constant source.** Codes that point at the appended constant, or past the last source, are checked. An off-by-one decoder would then leak a data input, or the wrong constant, onto the output.

// File: rtl/rmux_pkg.sv
package rmux_pkg;

    typedef enum logic [1:0] {
        SEL_ONEHOT  = 2'd0,
        SEL_TREE    = 2'd1,
        SEL_ENCODED = 2'd2
    } sel_style_e;

    // Width of a binary code able to name n sources.
    function automatic int code_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Configuration vector width for a style and source count.
    function automatic int cfg_bits(input sel_style_e s, input int n);
        case (s)
            SEL_TREE:    return n - 1;
            SEL_ENCODED: return code_bits(n);
            default:     return n;
        endcase
    endfunction

    // Source reached when every tree node takes its left child.
    function automatic int tree_leftmost(input int n);
        int idx;
        idx = 0;
        while (idx < n - 1) idx = 2 * idx + 1;
        return idx - (n - 1);
    endfunction

endpackage

// File: rtl/rmux_bin_decoder.sv
module rmux_bin_decoder #(
    parameter int N_SRC  = 8,
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] code,
    output logic [N_SRC-1:0]  onehot
);

    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            onehot[i] = (code == CODE_W'(i));
        end
    end

    always_comb begin
        // R4
        dec_onehot0_chk: assert ($onehot0(onehot))
            else $error("decoder produced more than one select");
        if (int'(code) >= N_SRC) begin
            // R5
            dec_range_chk: assert (onehot == '0)
                else $error("out-of-range code selected a source");
        end
    end

endmodule

// File: rtl/rmux_onehot_sel.sv
module rmux_onehot_sel #(
    parameter int N_SRC = 4
) (
    input  logic [N_SRC-1:0] src,
    input  logic [N_SRC-1:0] sel,
    output logic             pick
);

    // Lowest set index wins; nothing set gives 0.
    always_comb begin
        pick = 1'b0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (sel[i]) pick = src[i];
        end
    end

    always_comb begin
        if (sel == '0) begin
            // R2
            none_sel_zero_chk: assert (pick == 1'b0)
                else $error("empty select drove a 1");
        end
        if ($onehot(sel)) begin
            // R1
            onehot_pick_chk: assert (pick == |(src & sel))
                else $error("single select did not pass its source");
        end
    end

endmodule

// File: rtl/rmux_tree.sv
module rmux_tree #(
    parameter int N_SRC = 4
) (
    input  logic [N_SRC-1:0] src,
    input  logic [N_SRC-2:0] node_cfg,
    output logic             pick
);

    localparam int NODE_CNT = 2 * N_SRC - 1;
    localparam int LEAF_LO  = N_SRC - 1;
    localparam int LEFT_SRC = rmux_pkg::tree_leftmost(N_SRC);

    logic [NODE_CNT-1:0] node_val;

    // Leaves first, then each 2:1 node from the bottom up to the root.
    always_comb begin
        node_val = '0;
        for (int j = 0; j < N_SRC; j++) begin
            node_val[LEAF_LO + j] = src[j];
        end
        for (int k = N_SRC - 2; k >= 0; k--) begin
            node_val[k] = node_cfg[k] ? node_val[2 * k + 2] : node_val[2 * k + 1];
        end
    end

    assign pick = node_val[0];

    always_comb begin
        if (node_cfg == '0) begin
            // R3
            tree_left_path_chk: assert (pick == src[LEFT_SRC])
                else $error("all-left tree path picked the wrong source");
        end
    end

endmodule

// File: rtl/rmux_route.sv
module rmux_route
    import rmux_pkg::*;
#(
    parameter int         N_IN      = 4,
    parameter sel_style_e STYLE     = SEL_ONEHOT,
    parameter bit         CONST_EN  = 1'b0,
    parameter bit         CONST_VAL = 1'b0
) (
    input  logic [rmux_pkg::cfg_bits(STYLE, N_IN + int'(CONST_EN))-1:0] cfg_in,
    input  logic [N_IN-1:0] data_in,
    output logic            mux_out
);

    localparam int N_SRC = N_IN + int'(CONST_EN);
    localparam int CFG_W = cfg_bits(STYLE, N_SRC);

    logic [N_SRC-1:0] src_vec;

    generate
        if (CONST_EN) begin : g_const
            assign src_vec = {CONST_VAL, data_in};
        end else begin : g_plain
            assign src_vec = data_in;
        end

        if (STYLE == SEL_TREE) begin : g_tree
            rmux_tree #(.N_SRC(N_SRC)) u_tree (
                .src      (src_vec),
                .node_cfg (cfg_in),
                .pick     (mux_out)
            );
        end else if (STYLE == SEL_ENCODED) begin : g_enc
            logic [N_SRC-1:0] dec_sel;
            rmux_bin_decoder #(.N_SRC(N_SRC), .CODE_W(CFG_W)) u_dec (
                .code   (cfg_in),
                .onehot (dec_sel)
            );
            rmux_onehot_sel #(.N_SRC(N_SRC)) u_sel (
                .src  (src_vec),
                .sel  (dec_sel),
                .pick (mux_out)
            );
        end else begin : g_flat
            rmux_onehot_sel #(.N_SRC(N_SRC)) u_sel (
                .src  (src_vec),
                .sel  (cfg_in),
                .pick (mux_out)
            );
        end
    endgenerate

    always_comb begin
        if (CONST_EN && STYLE == SEL_ONEHOT && cfg_in == CFG_W'(1 << N_IN)) begin
            // R6
            const_src_chk: assert (mux_out == CONST_VAL)
                else $error("constant source not driven to output");
        end
    end

endmodule

// File: tb/rmux_route_bench.sv
module rmux_route_bench;
    import rmux_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // Flat one-hot, 4 inputs
    logic [3:0] oh4_c, oh4_d;  logic oh4_o;
    // Tree, 4 and 8 inputs
    logic [2:0] tr4_c; logic [3:0] tr4_d; logic tr4_o;
    logic [6:0] tr8_c; logic [7:0] tr8_d; logic tr8_o;
    // Encoded, 8 inputs
    logic [2:0] en8_c; logic [7:0] en8_d; logic en8_o;
    // Flat one-hot, 8 inputs
    logic [7:0] oh8_c, oh8_d;  logic oh8_o;
    // Flat one-hot, 4 inputs + constant 1
    logic [4:0] ohc_c; logic [3:0] ohc_d; logic ohc_o;
    // Encoded, 4 inputs + default constant
    logic [2:0] enc_c; logic [3:0] enc_d; logic enc_o;

    rmux_route #(.N_IN(4), .STYLE(SEL_ONEHOT)) u_rmux_route (
        .cfg_in(oh4_c), .data_in(oh4_d), .mux_out(oh4_o));
    rmux_route #(.N_IN(4), .STYLE(SEL_TREE)) u_rmux_route_tr4 (
        .cfg_in(tr4_c), .data_in(tr4_d), .mux_out(tr4_o));
    rmux_route #(.N_IN(8), .STYLE(SEL_TREE)) u_rmux_route_tr8 (
        .cfg_in(tr8_c), .data_in(tr8_d), .mux_out(tr8_o));
    rmux_route #(.N_IN(8), .STYLE(SEL_ENCODED)) u_rmux_route_en8 (
        .cfg_in(en8_c), .data_in(en8_d), .mux_out(en8_o));
    rmux_route #(.N_IN(8), .STYLE(SEL_ONEHOT)) u_rmux_route_oh8 (
        .cfg_in(oh8_c), .data_in(oh8_d), .mux_out(oh8_o));
    rmux_route #(.N_IN(4), .STYLE(SEL_ONEHOT), .CONST_EN(1'b1), .CONST_VAL(1'b1)) u_rmux_route_ohc (
        .cfg_in(ohc_c), .data_in(ohc_d), .mux_out(ohc_o));
    rmux_route #(.N_IN(4), .STYLE(SEL_ENCODED), .CONST_EN(1'b1)) u_rmux_route_enc (
        .cfg_in(enc_c), .data_in(enc_d), .mux_out(enc_o));

    // Directed vectors for the 4-input one-hot instance: {cfg, data, expected}
    localparam logic [8:0] VEC [8] = '{
        {4'b0001, 4'b0001, 1'b1},
        {4'b0001, 4'b1110, 1'b0},
        {4'b0100, 4'b0100, 1'b1},
        {4'b1000, 4'b0111, 1'b0},
        {4'b0110, 4'b0100, 1'b0},
        {4'b0110, 4'b0010, 1'b1},
        {4'b0000, 4'b1111, 1'b0},
        {4'b1111, 4'b1110, 1'b0}
    };

    // Expected-value models, written from the requirements.
    function automatic logic ref_onehot(input logic [8:0] src, input int n, input logic [8:0] cfg);
        for (int i = 0; i < n; i++) if (cfg[i]) return src[i];
        return 1'b0;
    endfunction

    function automatic logic ref_tree(input logic [8:0] src, input int n, input logic [8:0] cfg);
        int node;
        node = 0;
        while (node < n - 1) node = cfg[node] ? 2 * node + 2 : 2 * node + 1;
        return src[node - (n - 1)];
    endfunction

    function automatic logic ref_code(input logic [8:0] src, input int n, input int code);
        return (code < n) ? src[code] : 1'b0;
    endfunction

    task automatic check(input string req, input logic got, input logic exp, input int cfg, input int dat);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s cfg=%0h data=%0h actual=%0b expected=%0b", req, cfg, dat, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 200000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        oh4_c = '0; oh4_d = '0; tr4_c = '0; tr4_d = '0; tr8_c = '0; tr8_d = '0;
        en8_c = '0; en8_d = '0; oh8_c = '0; oh8_d = '0; ohc_c = '0; ohc_d = '0;
        enc_c = '0; enc_d = '0;
        #1;
        // Initial state: empty one-hot select gives 0 (R2)
        oh4_d = 4'hF;
        #1;
        check("R2", oh4_o, 1'b0, 0, 15);

        // Table walk on the 4-input one-hot instance (R1, R2)
        for (int v = 0; v < 8; v++) begin
            oh4_c = VEC[v][8:5];
            oh4_d = VEC[v][4:1];
            #1;
            check(($countones(VEC[v][8:5]) == 1) ? "R1" : "R2", oh4_o, VEC[v][0], VEC[v][8:5], VEC[v][4:1]);
        end

        // R7: data change alone updates the output without any clock edge
        oh4_c = 4'b0010; oh4_d = 4'b0000;
        #0.5;
        oh4_d = 4'b0010;
        #0.5;
        check("R7", oh4_o, 1'b1, 2, 2);

        // Exhaustive sweeps
        for (int d = 0; d < 16; d++) begin
            for (int c = 0; c < 16; c++) begin
                oh4_c = 4'(c); oh4_d = 4'(d);
                #1;
                check(($countones(c) == 1) ? "R1" : "R2", oh4_o, ref_onehot(9'(d), 4, 9'(c)), c, d);
            end
            for (int c = 0; c < 8; c++) begin
                tr4_c = 3'(c); tr4_d = 4'(d);
                #1;
                check("R3", tr4_o, ref_tree(9'(d), 4, 9'(c)), c, d);
            end
        end

        for (int d = 0; d < 256; d++) begin
            for (int c = 0; c < 256; c++) begin
                oh8_c = 8'(c); oh8_d = 8'(d);
                #1;
                check(($countones(c) == 1) ? "R1" : "R2", oh8_o, ref_onehot(9'(d), 8, 9'(c)), c, d);
            end
            for (int c = 0; c < 128; c++) begin
                tr8_c = 7'(c); tr8_d = 8'(d);
                #1;
                check("R3", tr8_o, ref_tree(9'(d), 8, 9'(c)), c, d);
            end
            for (int c = 0; c < 8; c++) begin
                en8_c = 3'(c); en8_d = 8'(d);
                #1;
                check("R4", en8_o, ref_code(9'(d), 8, c), c, d);
            end
        end

        // Constant source, value 1, flat one-hot (R6)
        for (int d = 0; d < 16; d++) begin
            ohc_d = 4'(d);
            ohc_c = 5'b10000;
            #1;
            check("R6", ohc_o, 1'b1, 16, d);
            for (int c = 0; c < 32; c++) begin
                ohc_c = 5'(c);
                #1;
                check("R6", ohc_o, ref_onehot({5'b00001, 4'(d)}, 5, 9'(c)), c, d);
            end
        end

        // Encoded with default constant 0: code 4 hits the constant (R6),
        // codes 5..7 are out of range (R5)
        for (int d = 0; d < 16; d++) begin
            for (int c = 0; c < 8; c++) begin
                enc_c = 3'(c); enc_d = 4'(d);
                #1;
                if (c < 4)       check("R4", enc_o, 1'(d >> c), c, d);
                else if (c == 4) check("R6", enc_o, 1'b0, c, d);
                else             check("R5", enc_o, 1'b0, c, d);
            end
        end

        finish_run();
    end

endmodule